// File: doc/BRIEF.md
# Redundant Serial Test and Monitor Relay

This block sits between a supervisory controller and a group of remote user interfaces and relays serial traffic both ways. In the test direction the controller writes a data buffer over a serial link. The block stores it and, once per transmit period, sends it downstream. In the monitor direction the block takes the most recent data returned by the user side, adds a 16-bit word describing its own state, and sends the combined frame upstream in the same period. The upstream payload is also held on a parallel port that drives display LEDs.

Every path is a pair of links. Both receive links of a pair are decoded all the time. The block takes data only from the selected link. When the selected link stops delivering good frames and its partner still does, the block moves to the partner on its own. Both transmit links of a pair carry the same frame. The transmit period comes from a tick divider. The default gives two frames per second at 100 MHz, and a smaller divider raises the rate.

On the serial lines one bit is sent per clock. The idle level is 0. A frame begins with a single 1 start bit, then carries the payload MSB first, then an 8-bit check byte. The check byte is the XOR of the payload bytes.

Top module: `dual_path_relay`

## Requirements
- R1: After reset all four transmit lines are low, `led_o` is zero, the primary (A) link of each pair is selected and no link is faulted.
- R2: No downstream or upstream frame is sent until a valid test buffer has been received from the controller.
- R3: A frame is a 1 start bit, the payload MSB first, then a check byte equal to the XOR of all payload bytes, one bit per clock, with the line held at 0 when idle.
- R4: A received frame whose check byte does not match is discarded and leaves the stored buffer unchanged.
- R5: Once a buffer is held, the stored test buffer is sent on both downstream links, with the same content on each, every TICK_DIV clock cycles.
- R6: In the same period the upstream frame is sent on both upstream links. Its payload is {monitor data, status word}, with the monitor data in the upper MON_W bits.
- R7: A link with no valid frame during MISS_LIMIT tick periods is faulted. The selector moves away from a faulted active link only when its partner is healthy. A valid frame clears that link's fault. The selector does not move back while the active link is healthy.
- R8: Status word layout: bit 15 = controller pair select (1 = B), bit 14 = user pair select, bit 13 = controller A fault, bit 12 = controller B fault, bit 11 = user A fault, bit 10 = user B fault, bits 9:8 = 0, bits 7:0 = frames sent.
- R9: The frames-sent count is 0 in the first upstream frame, rises by one per frame and wraps from 255 to 0.
- R10: `led_o` equals the payload of the upstream frame most recently started and changes only when a new one starts.
- R11: Monitor data and test data are taken only from the selected link of each pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_rx_a | input | 1 | Test data from controller, link A |
| ctl_rx_b | input | 1 | Test data from controller, link B |
| ctl_tx_a | output | 1 | Upstream frame to controller, link A |
| ctl_tx_b | output | 1 | Upstream frame to controller, link B |
| usr_rx_a | input | 1 | Monitor data from user side, link A |
| usr_rx_b | input | 1 | Monitor data from user side, link B |
| usr_tx_a | output | 1 | Downstream test frame, link A |
| usr_tx_b | output | 1 | Downstream test frame, link B |
| led_o | output | MON_W+16 | Parallel copy of the last upstream payload |

## Verification
The bound checker watches several properties on every clock. It checks that the lines stay silent before the first buffer and that the selector leaves a faulted link when the partner is healthy. It also checks that the selector holds still while the active link is healthy and that the stored buffer moves only on a valid frame from the selected link. The LED word must change only at a transmit tick, and the frame counter must step by one per frame. Other behaviour can only be shown by the bench's scenarios: the bit-level frame content, the rejection of corrupted check bytes, data reaching the output through the partner link after a failover, and the counter wrapping after 256 frames.

// File: rtl/relay_pkg.sv
package relay_pkg;
    localparam int CS_MAXW = 64;
    localparam int STAT_W  = 16;
    localparam int CNT_W   = 8;

    // XOR of all bytes; callers zero-extend, zero bytes leave the result unchanged
    function automatic logic [7:0] xor_bytes(input logic [CS_MAXW-1:0] v);
        logic [7:0] acc;
        acc = '0;
        for (int i = 0; i < CS_MAXW / 8; i++) begin
            acc = acc ^ v[i*8 +: 8];
        end
        return acc;
    endfunction
endpackage

// File: rtl/frame_rx.sv
module frame_rx
    import relay_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx,
    output logic         valid,
    output logic [W-1:0] data
);
    localparam int FL = W + 8;
    localparam int CW = $clog2(FL + 1);

    typedef struct packed {
        logic [CW-1:0] left;
        logic [FL-2:0] sh;
        logic          valid;
        logic [W-1:0]  data;
    } rx_t;

    rx_t         q_q, q_d;
    logic [FL-1:0] sh_n;

    always_comb begin
        q_d       = q_q;
        q_d.valid = 1'b0;
        sh_n      = {q_q.sh, rx};
        if (q_q.left == '0) begin
            if (rx) begin
                q_d.left = CW'(FL);
            end
        end else begin
            q_d.sh   = sh_n[FL-2:0];
            q_d.left = q_q.left - 1'b1;
            if (q_q.left == CW'(1) &&
                xor_bytes(CS_MAXW'(sh_n[FL-1:8])) == sh_n[7:0]) begin
                q_d.valid = 1'b1;
                q_d.data  = sh_n[FL-1:8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign valid = q_q.valid;
    assign data  = q_q.data;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import relay_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] data,
    output logic         tx
);
    localparam int FL = W + 9;
    localparam int CW = $clog2(FL + 1);

    typedef struct packed {
        logic [CW-1:0] left;
        logic [FL-1:0] sh;
    } tx_t;

    tx_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (q_q.left != '0) begin
            q_d.sh   = {q_q.sh[FL-2:0], 1'b0};
            q_d.left = q_q.left - 1'b1;
        end else if (go) begin
            q_d.sh   = {1'b1, data, xor_bytes(CS_MAXW'(data))};
            q_d.left = CW'(FL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign tx = (q_q.left != '0) & q_q.sh[FL-1];
endmodule

// File: rtl/dual_path_relay.sv
module dual_path_relay
    import relay_pkg::*;
#(
    parameter int TEST_W     = 16,
    parameter int MON_W      = 16,
    parameter int TICK_DIV   = 50_000_000,
    parameter int MISS_LIMIT = 3,
    localparam int UP_W      = MON_W + STAT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_rx_a,
    input  logic            ctl_rx_b,
    output logic            ctl_tx_a,
    output logic            ctl_tx_b,
    input  logic            usr_rx_a,
    input  logic            usr_rx_b,
    output logic            usr_tx_a,
    output logic            usr_tx_b,
    output logic [UP_W-1:0] led_o
);
    localparam int TCW = $clog2(TICK_DIV);
    localparam int MCW = $clog2(MISS_LIMIT + 1);

    typedef struct packed {
        logic [TCW-1:0]          tick_cnt;
        logic                    have;
        logic [TEST_W-1:0]       test_buf;
        logic [MON_W-1:0]        mon_buf;
        logic                    sel_ctl;
        logic                    sel_usr;
        logic [3:0][MCW-1:0]     miss;
        logic [CNT_W-1:0]        sent;
        logic [UP_W-1:0]         led;
    } st_t;

    st_t st_q, st_d;

    // link index: 0 ctl A, 1 ctl B, 2 usr A, 3 usr B
    logic [1:0]             ctl_rx_v, usr_rx_v;
    logic [3:0]             valid_v;
    logic [1:0][TEST_W-1:0] ctl_data;
    logic [1:0][MON_W-1:0]  usr_data;
    logic [3:0]             fault;
    logic                   tick, send;
    logic [STAT_W-1:0]      status;
    logic                   down_line, up_line;

    assign ctl_rx_v = {ctl_rx_b, ctl_rx_a};
    assign usr_rx_v = {usr_rx_b, usr_rx_a};

    for (genvar g = 0; g < 2; g++) begin : g_pair
        frame_rx #(.W(TEST_W)) u_ctl_rx (
            .clk(clk), .rst_n(rst_n), .rx(ctl_rx_v[g]),
            .valid(valid_v[g]), .data(ctl_data[g])
        );
        frame_rx #(.W(MON_W)) u_usr_rx (
            .clk(clk), .rst_n(rst_n), .rx(usr_rx_v[g]),
            .valid(valid_v[g+2]), .data(usr_data[g])
        );
    end

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            fault[i] = (st_q.miss[i] == MCW'(MISS_LIMIT));
        end
    end

    assign tick   = (st_q.tick_cnt == TCW'(TICK_DIV - 1));
    assign send   = tick & st_q.have;
    assign status = {st_q.sel_ctl, st_q.sel_usr, fault[0], fault[1],
                     fault[2], fault[3], 2'b00, st_q.sent};

    always_comb begin
        st_d          = st_q;
        st_d.tick_cnt = tick ? '0 : st_q.tick_cnt + 1'b1;

        for (int i = 0; i < 4; i++) begin
            if (valid_v[i]) begin
                st_d.miss[i] = '0;
            end else if (tick && !fault[i]) begin
                st_d.miss[i] = st_q.miss[i] + 1'b1;
            end
        end

        if ((st_q.sel_ctl ? fault[1] : fault[0]) &&
            !(st_q.sel_ctl ? fault[0] : fault[1])) begin
            st_d.sel_ctl = !st_q.sel_ctl;
        end
        if ((st_q.sel_usr ? fault[3] : fault[2]) &&
            !(st_q.sel_usr ? fault[2] : fault[3])) begin
            st_d.sel_usr = !st_q.sel_usr;
        end

        if (st_q.sel_ctl ? valid_v[1] : valid_v[0]) begin
            st_d.test_buf = ctl_data[st_q.sel_ctl];
            st_d.have     = 1'b1;
        end
        if (st_q.sel_usr ? valid_v[3] : valid_v[2]) begin
            st_d.mon_buf = usr_data[st_q.sel_usr];
        end

        if (send) begin
            st_d.sent = st_q.sent + 1'b1;
            st_d.led  = {st_q.mon_buf, status};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    frame_tx #(.W(TEST_W)) u_down_tx (
        .clk(clk), .rst_n(rst_n), .go(send), .data(st_q.test_buf), .tx(down_line)
    );
    frame_tx #(.W(UP_W)) u_up_tx (
        .clk(clk), .rst_n(rst_n), .go(send), .data({st_q.mon_buf, status}), .tx(up_line)
    );

    assign usr_tx_a = down_line;
    assign usr_tx_b = down_line;
    assign ctl_tx_a = up_line;
    assign ctl_tx_b = up_line;
    assign led_o    = st_q.led;
endmodule

// File: rtl/relay_checker.sv
module relay_checker #(
    parameter int TEST_W = 16,
    parameter int UP_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              have,
    input logic              sel_ctl,
    input logic              sel_usr,
    input logic [3:0]        fault,
    input logic [1:0]        ctl_valid,
    input logic [TEST_W-1:0] test_buf,
    input logic [7:0]        sent,
    input logic [UP_W-1:0]   led,
    input logic              up_line,
    input logic              down_line
);
    assert_quiet_until_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !have |-> (!up_line && !down_line));

    assert_ctl_switch_away_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ctl && fault[0] && !fault[1]) |=> sel_ctl);

    assert_usr_switch_away_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_usr && fault[2] && !fault[3]) |=> sel_usr);

    assert_ctl_hold_healthy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ctl ? fault[1] : fault[0]) |=> $stable(sel_ctl));

    assert_buffer_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ctl ? ctl_valid[1] : ctl_valid[0]) |=> $stable(test_buf));

    assert_led_only_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && have) |=> $stable(led));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && have) |=> (sent == $past(sent) + 8'd1));
endmodule

bind dual_path_relay relay_checker #(.TEST_W(TEST_W), .UP_W(UP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .have(st_q.have),
    .sel_ctl(st_q.sel_ctl), .sel_usr(st_q.sel_usr), .fault(fault),
    .ctl_valid(valid_v[1:0]), .test_buf(st_q.test_buf), .sent(st_q.sent),
    .led(led_o), .up_line(ctl_tx_a), .down_line(usr_tx_a)
);

// File: tb/tb_dual_path_relay.sv
module tb_dual_path_relay;
    localparam int TICK = 100;
    localparam int W    = 16;

    logic clk = 0, rst_n = 0;
    logic ctl_rx_a = 0, ctl_rx_b = 0, usr_rx_a = 0, usr_rx_b = 0;
    logic ctl_tx_a, ctl_tx_b, usr_tx_a, usr_tx_b;
    logic [31:0] led_o;

    dual_path_relay #(.TEST_W(W), .MON_W(W), .TICK_DIV(TICK), .MISS_LIMIT(3)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_rx_a(ctl_rx_a), .ctl_rx_b(ctl_rx_b),
        .ctl_tx_a(ctl_tx_a), .ctl_tx_b(ctl_tx_b), .usr_rx_a(usr_rx_a), .usr_rx_b(usr_rx_b),
        .usr_tx_a(usr_tx_a), .usr_tx_b(usr_tx_b), .led_o(led_o)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    longint cycle = 0;
    always @(posedge clk) cycle <= cycle + 1;

    logic [3:0] en = '0, bad = '0;
    logic [W-1:0] test_data = '0, mon_data = '0;

    logic [39:0] pay_da, pay_db, pay_ua, pay_ub;
    logic ok_da, ok_db, ok_ua, ok_ub;
    longint t_da, t_db, t_ua, t_ub;

    function automatic logic [7:0] xb40(input logic [39:0] v);
        return v[39:32] ^ v[31:24] ^ v[23:16] ^ v[15:8] ^ v[7:0];
    endfunction

    // expected status bits 15:8
    function automatic logic [7:0] stat_hi(input bit sc, input bit su, input logic [3:0] f);
        return {sc, su, f[0], f[1], f[2], f[3], 2'b00};
    endfunction

    task automatic chk(input bit good, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input int ln, input logic b);
        case (ln)
            0: ctl_rx_a = b;
            1: ctl_rx_b = b;
            2: usr_rx_a = b;
            default: usr_rx_b = b;
        endcase
    endtask

    function automatic logic line(input int ln);
        case (ln)
            0: return usr_tx_a;
            1: return usr_tx_b;
            2: return ctl_tx_a;
            default: return ctl_tx_b;
        endcase
    endfunction

    task automatic feeder(input int ln);
        logic [W-1:0] p;
        logic [W+8:0] fr;
        forever begin
            repeat (70) @(negedge clk);
            if (en[ln]) begin
                p  = (ln < 2) ? test_data : mon_data;
                fr = {1'b1, p, xb40(40'(p)) ^ (bad[ln] ? 8'hA5 : 8'h00)};
                for (int k = W + 8; k >= 0; k--) begin
                    drive(ln, fr[k]);
                    @(negedge clk);
                end
                drive(ln, 1'b0);
            end
        end
    endtask

    initial feeder(0);
    initial feeder(1);
    initial feeder(2);
    initial feeder(3);

    // waits for an idle gap, then decodes one frame of nbits payload
    task automatic grab(input int ln, input int nbits, output logic [39:0] pay,
                        output logic ok, output longint ts);
        int z = 0;
        logic [47:0] fr = '0;
        while (z < 50) begin
            @(negedge clk);
            z = line(ln) ? 0 : z + 1;
        end
        while (!line(ln)) @(negedge clk);
        ts = cycle;
        for (int k = 0; k < nbits + 8; k++) begin
            @(negedge clk);
            fr = {fr[46:0], line(ln)};
        end
        pay = fr[47:8];
        ok  = (xb40(pay) == fr[7:0]);
    endtask

    task automatic grab_all();
        fork
            grab(0, W, pay_da, ok_da, t_da);
            grab(1, W, pay_db, ok_db, t_db);
            grab(2, 2*W, pay_ua, ok_ua, t_ua);
            grab(3, 2*W, pay_ub, ok_ub, t_ub);
        join
    endtask

    task automatic check_round(input string tag, input bit sc, input bit su, input logic [3:0] f);
        chk(ok_da && pay_da == 40'(test_data), {tag, " R3 R5 R11 downstream content"}, pay_da, 40'(test_data));
        chk(pay_db == pay_da && ok_db, {tag, " R5 downstream pair match"}, pay_db, pay_da);
        chk(ok_ua && pay_ua[31:16] == mon_data, {tag, " R6 R11 upstream monitor"}, pay_ua, 40'(mon_data));
        chk(pay_ub == pay_ua && ok_ub, {tag, " R6 upstream pair match"}, pay_ub, pay_ua);
        chk(pay_ua[15:8] == stat_hi(sc, su, f), {tag, " R7 R8 status"}, 40'(pay_ua[15:8]), 40'(stat_hi(sc, su, f)));
        chk(led_o == pay_ua[31:0], {tag, " R10 led copy"}, 40'(led_o), pay_ua);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [W-1:0] old;
        bit quiet;
        logic [7:0] c1;
        longint t1;
        void'($urandom(32'd1234));

        repeat (5) @(negedge clk);
        chk({ctl_tx_a, ctl_tx_b, usr_tx_a, usr_tx_b} == 4'b0 && led_o == '0, "R1 reset outputs",
            40'({ctl_tx_a, ctl_tx_b, usr_tx_a, usr_tx_b, led_o}), 40'd0);
        rst_n = 1;

        // R2: silence with no buffer
        quiet = 1;
        for (int i = 0; i < 5 * TICK; i++) begin
            @(negedge clk);
            if (ctl_tx_a | ctl_tx_b | usr_tx_a | usr_tx_b) quiet = 0;
        end
        chk(quiet && led_o == '0, "R2 no frames before first buffer", 40'(quiet), 40'd1);

        // first frames: count 0, primaries, no faults
        test_data = 16'h5AC3;
        mon_data  = 16'h9E21;
        en = 4'hF;
        grab_all();
        check_round("first", 0, 0, 4'b0000);
        chk(pay_ua[7:0] == 8'd0, "R1 R9 first count zero", 40'(pay_ua[7:0]), 40'd0);

        // consecutive frames: count step and period
        grab(2, 2*W, pay_ua, ok_ua, t1);
        c1 = pay_ua[7:0];
        grab(2, 2*W, pay_ua, ok_ua, t_ua);
        chk(pay_ua[7:0] == c1 + 8'd1, "R9 count step", 40'(pay_ua[7:0]), 40'(c1 + 8'd1));
        chk(t_ua - t1 == TICK, "R5 transmit period", 40'(t_ua - t1), 40'(TICK));

        // random and directed data rounds
        for (int r = 0; r < 8; r++) begin
            test_data = (r == 0) ? 16'h0000 : (r == 1) ? 16'hFFFF : W'($urandom);
            mon_data  = (r == 0) ? 16'hFFFF : (r == 1) ? 16'h0001 : W'($urandom);
            repeat (250) @(negedge clk);
            grab_all();
            check_round("random", 0, 0, 4'b0000);
        end

        // R4: corrupted check bytes are dropped
        old = test_data;
        bad = 4'b0011;
        test_data = ~old;
        repeat (250) @(negedge clk);
        grab(0, W, pay_da, ok_da, t_da);
        chk(pay_da == 40'(old), "R4 bad frame ignored", pay_da, 40'(old));
        bad = 4'b0000;
        repeat (250) @(negedge clk);
        grab(0, W, pay_da, ok_da, t_da);
        chk(pay_da == 40'(test_data), "R4 good frame after recovery", pay_da, 40'(test_data));

        // R7: A links break, selector moves to B
        en = 4'b1010;
        test_data = W'($urandom);
        mon_data  = W'($urandom);
        repeat (700) @(negedge clk);
        grab_all();
        check_round("failover to B", 1, 1, 4'b0101);

        // R7: A links heal, selection stays on B
        en = 4'hF;
        repeat (300) @(negedge clk);
        grab_all();
        check_round("A healed", 1, 1, 4'b0000);

        // R7: B links break, selector returns to A
        en = 4'b0101;
        test_data = W'($urandom);
        mon_data  = W'($urandom);
        repeat (700) @(negedge clk);
        grab_all();
        check_round("failover to A", 0, 0, 4'b1010);

        // R9: wrap of the frame counter
        en = 4'hF;
        grab(2, 2*W, pay_ua, ok_ua, t_ua);
        while (pay_ua[7:0] != 8'hFF) grab(2, 2*W, pay_ua, ok_ua, t_ua);
        grab(2, 2*W, pay_ua, ok_ua, t_ua);
        chk(pay_ua[7:0] == 8'h00, "R9 count wraps", 40'(pay_ua[7:0]), 40'd0);

        finish_up();
    end
endmodule